// File: doc/BRIEF.md
# Atomic Read-Modify-Write Word Store

This block is a small shared word memory with several requester slots. It carries out each access as one indivisible step. In the granting cycle it reads the addressed word, computes a replacement value and, where the opcode calls for it, writes that value back. A registered response returns the prior content of the word and a success bit. Software-style locks, counters and lock-free updates can be built on it without separate load and store transactions.

Any number of requesters may raise a request in the same cycle. A round-robin arbiter grants one of them combinationally in that cycle. The whole read-then-write finishes at the next clock edge, so the following operation on the same word always sees the updated value. Releasing a lock is a plain write of zero.

Opcodes (3 bits): 0 = read, 1 = write, 2 = exchange, 3 = test-and-set, 4 = compare-and-swap, 5 = fetch-and-increment. Codes 6 and 7 are reserved.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Reset clears every word to zero and holds rsp_valid low; a read after reset returns 0.
- R2: Opcode 0 (read) returns the word with flag 1 and leaves it unchanged; opcode 1 (write) stores the supplied value and returns the prior word with flag 1.
- R3: Opcode 2 (exchange) stores the supplied value and returns the prior word with flag 1.
- R4: Opcode 3 (test-and-set) always stores 1 and returns the prior word; the flag is 1 only when the prior word was 0 (lock taken).
- R5: Opcode 4 (compare-and-swap) stores the new value only when the word equals the compare value; the flag reports that equality, and on a mismatch the word is unchanged.
- R6: Opcode 5 (fetch-and-increment) returns the prior word and stores it plus one, modulo 2^32.
- R7: Reserved opcodes 6 and 7 return the word with flag 0 and do not modify it.
- R8: A grant in cycle t yields rsp_valid, rsp_id (winner index), rsp_old and rsp_flag in cycle t+1; a cycle with no grant yields rsp_valid low in the next cycle.
- R9: req_grant is combinational in the request cycle, has at most one bit set, and is set only for a requester whose valid is high.
- R10: Grants rotate. The search starts at a pointer that is 0 after reset and moves to the winner index plus one. A requester is granted twice in a row only when no other requester is waiting.
- R11: Operations granted in consecutive cycles on the same word each observe the result of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request raised, one bit per requester |
| req_op | input | NUM_REQ*3 | Opcode, requester i at bits [3i+2:3i] |
| req_addr | input | NUM_REQ*ADDR_W | Word address per requester |
| req_wdata | input | NUM_REQ*DATA_W | Write, swap or new value per requester |
| req_cmp | input | NUM_REQ*DATA_W | Compare value for compare-and-swap |
| req_grant | output | NUM_REQ | One-hot grant in the request cycle |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | ID_W | Index of the requester being answered |
| rsp_old | output | DATA_W | Word content before the operation |
| rsp_flag | output | 1 | Success / compare result |

## Verification
The assertions assume a requester keeps its fields stable while its valid bit is high. They also assume no request is raised while reset is active, so the first grant after reset comes from a pointer of zero. The bench changes inputs only on falling edges, holds contending requests across cycles until the expected grants have been seen, and clears all valid bits during reset. The rotation property compares the grant against the previous cycle only after one clean cycle out of reset.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_XCHG  = 3'd2,
    OP_TAS   = 3'd3,
    OP_CAS   = 3'd4,
    OP_FINC  = 3'd5
  } rmw_op_e;
endpackage

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
  parameter int N    = 4,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  output logic [N-1:0]    grant,
  output logic [ID_W-1:0] win_idx,
  output logic            any_grant
);
  logic [ID_W-1:0] ptr_q;

  always_comb begin
    grant     = '0;
    win_idx   = '0;
    any_grant = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % N;
      if (!any_grant && req[idx]) begin
        any_grant  = 1'b1;
        grant[idx] = 1'b1;
        win_idx    = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (any_grant)
      ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + ID_W'(1);
  end

  // one clean cycle out of reset before comparing against the previous grant
  logic hist_ok_q;
  always_ff @(posedge clk) begin
    if (!rst_n) hist_ok_q <= 1'b0;
    else        hist_ok_q <= 1'b1;
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  p_no_repeat_when_others_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok_q && any_grant && grant == $past(grant)) |-> ((req & ~grant) == '0));
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write,
  output logic              success
);
  typedef struct packed {
    logic [DATA_W-1:0] nv;
    logic              wr;
    logic              ok;
  } rmw_res_t;

  function automatic rmw_res_t compute(input logic [OP_W-1:0] o,
                                       input logic [DATA_W-1:0] cur,
                                       input logic [DATA_W-1:0] wd,
                                       input logic [DATA_W-1:0] cv);
    rmw_res_t r;
    r.nv = cur;
    r.wr = 1'b0;
    r.ok = 1'b1;
    case (o)
      OP_READ:  ;
      OP_WRITE, OP_XCHG: begin
        r.nv = wd;
        r.wr = 1'b1;
      end
      OP_TAS: begin
        r.nv = DATA_W'(1);
        r.wr = 1'b1;
        r.ok = (cur == '0);
      end
      OP_CAS: begin
        r.ok = (cur == cv);
        r.wr = r.ok;
        r.nv = wd;
      end
      OP_FINC: begin
        r.nv = cur + DATA_W'(1);
        r.wr = 1'b1;
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  rmw_res_t res;
  always_comb begin
    res      = compute(op, old_val, wdata, cmp);
    new_val  = res.nv;
    do_write = res.wr;
    success  = res.ok;
  end
endmodule

// File: rtl/rmw_word_store.sv
module rmw_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[w] <= '0;
      else if (wr_en && addr == ADDR_W'(w))
        mem[w] <= wr_data;
    end
  end

  assign rd_data = mem[addr];

  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(addr)] == $past(wr_data)));
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REQ-1:0]          req_valid,
  input  logic [NUM_REQ*OP_W-1:0]     req_op,
  input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
  input  logic [NUM_REQ*DATA_W-1:0]   req_wdata,
  input  logic [NUM_REQ*DATA_W-1:0]   req_cmp,
  output logic [NUM_REQ-1:0]          req_grant,
  output logic                        rsp_valid,
  output logic [ID_W-1:0]             rsp_id,
  output logic [DATA_W-1:0]           rsp_old,
  output logic                        rsp_flag
);
  logic [ID_W-1:0]   win_idx;
  logic              any_grant;
  logic [OP_W-1:0]   sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata, sel_cmp;
  logic [DATA_W-1:0] cur_word, next_word;
  logic              alu_write, alu_ok, mem_we;

  rmw_rr_arbiter #(.N(NUM_REQ), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .grant(req_grant), .win_idx(win_idx), .any_grant(any_grant)
  );

  assign sel_op    = req_op   [win_idx*OP_W   +: OP_W];
  assign sel_addr  = req_addr [win_idx*ADDR_W +: ADDR_W];
  assign sel_wdata = req_wdata[win_idx*DATA_W +: DATA_W];
  assign sel_cmp   = req_cmp  [win_idx*DATA_W +: DATA_W];

  rmw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(sel_addr), .rd_data(cur_word),
    .wr_en(mem_we), .wr_data(next_word)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op(sel_op), .old_val(cur_word), .wdata(sel_wdata), .cmp(sel_cmp),
    .new_val(next_word), .do_write(alu_write), .success(alu_ok)
  );

  assign mem_we = any_grant & alu_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_old   <= '0;
      rsp_flag  <= 1'b0;
    end else begin
      rsp_valid <= any_grant;
      if (any_grant) begin
        rsp_id   <= win_idx;
        rsp_old  <= cur_word;
        rsp_flag <= alu_ok;
      end
    end
  end

  p_rsp_follows_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_grant) |=> rsp_valid);

  p_no_rsp_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_grant) |=> !rsp_valid);

  p_cas_miss_keeps_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && sel_op == OP_CAS && cur_word != sel_cmp) |-> !mem_we);

  p_tas_stores_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && sel_op == OP_TAS) |-> (mem_we && next_word == DATA_W'(1)));

  p_reserved_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && sel_op > OP_FINC) |-> !mem_we);
endmodule

// File: tb/atomic_rmw_unit_bench.sv
`timescale 1ns/1ps
module atomic_rmw_unit_bench;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam int VW = 3 + AW + DW + DW + DW + 1 + 4;
  localparam int NV = 20;

  // {op, addr, wdata, cmp, expected old, expected flag, requirement number}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 4'd3,  32'h0,        32'h0,  32'h0,        1'b1, 4'd2},  // R2 read fresh word
    {3'd1, 4'd3,  32'h55,       32'h0,  32'h0,        1'b1, 4'd2},  // R2 write
    {3'd0, 4'd3,  32'h0,        32'h0,  32'h55,       1'b1, 4'd2},  // R2 read back
    {3'd2, 4'd3,  32'hAA,       32'h0,  32'h55,       1'b1, 4'd3},  // R3 exchange
    {3'd0, 4'd3,  32'h0,        32'h0,  32'hAA,       1'b1, 4'd3},  // R3 result
    {3'd3, 4'd5,  32'h0,        32'h0,  32'h0,        1'b1, 4'd4},  // R4 lock taken
    {3'd3, 4'd5,  32'h0,        32'h0,  32'h1,        1'b0, 4'd4},  // R4 lock busy
    {3'd1, 4'd5,  32'h0,        32'h0,  32'h1,        1'b1, 4'd4},  // R4 release
    {3'd3, 4'd5,  32'h0,        32'h0,  32'h0,        1'b1, 4'd4},  // R4 retake
    {3'd4, 4'd3,  32'h77,       32'h12, 32'hAA,       1'b0, 4'd5},  // R5 mismatch
    {3'd0, 4'd3,  32'h0,        32'h0,  32'hAA,       1'b1, 4'd5},  // R5 untouched
    {3'd4, 4'd3,  32'h77,       32'hAA, 32'hAA,       1'b1, 4'd5},  // R5 match
    {3'd0, 4'd3,  32'h0,        32'h0,  32'h77,       1'b1, 4'd5},  // R5 stored
    {3'd5, 4'd15, 32'h0,        32'h0,  32'h0,        1'b1, 4'd6},  // R6
    {3'd5, 4'd15, 32'h0,        32'h0,  32'h1,        1'b1, 4'd6},  // R6
    {3'd1, 4'd15, 32'hFFFFFFFF, 32'h0,  32'h2,        1'b1, 4'd6},  // R6 preset max
    {3'd5, 4'd15, 32'h0,        32'h0,  32'hFFFFFFFF, 1'b1, 4'd6},  // R6 wrap
    {3'd0, 4'd15, 32'h0,        32'h0,  32'h0,        1'b1, 4'd6},  // R6 wrapped to 0
    {3'd7, 4'd3,  32'h99,       32'h77, 32'h77,       1'b0, 4'd7},  // R7 reserved
    {3'd0, 4'd3,  32'h0,        32'h0,  32'h77,       1'b1, 4'd7}   // R7 no effect
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_valid;
  logic [N*3-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata, req_cmp;
  logic [N-1:0]    req_grant;
  logic            rsp_valid, rsp_flag;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_old;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_old(rsp_old), .rsp_flag(rsp_flag)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; req_cmp = '0;
  endtask

  task automatic set_req(input int i, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] cv);
    req_valid[i]         = 1'b1;
    req_op[i*3 +: 3]     = op;
    req_addr[i*AW +: AW] = a;
    req_wdata[i*DW +: DW] = wd;
    req_cmp[i*DW +: DW]  = cv;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_reqs();
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", DW'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();

    // table walk on requester 0, one operation per cycle
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      string tg;
      e = VEC[v];
      tg = $sformatf("R%0d vec%0d", e[3:0], v);
      clear_reqs();
      set_req(0, e[VW-1 -: 3], e[VW-4 -: AW], e[3*DW+4 : 2*DW+5], e[2*DW+4 : DW+5]);
      #1 check({"R9 grant ", tg}, DW'(req_grant), DW'(1));
      @(negedge clk);
      check({"R8 valid ", tg}, DW'(rsp_valid), 1);
      check({"R8 id ", tg}, DW'(rsp_id), 0);
      check({"old ", tg}, rsp_old, e[DW+4:5]);
      check({"flag ", tg}, DW'(rsp_flag), DW'(e[4]));
    end
    clear_reqs();
    #1 check("R9 no grant when idle", DW'(req_grant), 0);
    @(negedge clk);
    check("R8 idle gives no response", DW'(rsp_valid), 0);

    // R1: reset clears previously written word
    do_reset();
    set_req(0, 3'd0, 4'd3, 0, 0);
    @(negedge clk);
    check("R1 word zero after reset", rsp_old, 0);
    clear_reqs();
    // pointer now 1

    // R10/R11: all four increment word 7, grants 1,2,3,0
    for (int k = 0; k < 4; k++) set_req(k, 3'd5, 4'd7, 0, 0);
    for (int k = 0; k < 4; k++) begin
      #1 check("R10 rotation grant", DW'(req_grant), DW'(1 << ((1 + k) % 4)));
      @(negedge clk);
      check("R8 rotation id", DW'(rsp_id), DW'((1 + k) % 4));
      check("R11 back-to-back increment", rsp_old, DW'(k));
    end
    clear_reqs();
    // pointer now 1; spinning test-and-set on 0 against a releaser on 2
    set_req(0, 3'd3, 4'd9, 0, 0);
    set_req(2, 3'd1, 4'd9, 0, 0);
    for (int k = 0; k < 4; k++) begin
      int w;
      w = (k % 2 == 0) ? 2 : 0;
      #1 check("R10 spinner does not starve", DW'(req_grant), DW'(1 << w));
      @(negedge clk);
      check("R8 spin id", DW'(rsp_id), DW'(w));
      check("R4 spin old", rsp_old, (w == 2 && k > 0) ? 1 : 0);
      check("R4 spin flag", DW'(rsp_flag), 1);
    end
    clear_reqs();
    // sole requester may win consecutive cycles; word 7 holds 4
    set_req(3, 3'd5, 4'd7, 0, 0);
    for (int k = 0; k < 2; k++) begin
      #1 check("R10 sole requester regranted", DW'(req_grant), DW'(8));
      @(negedge clk);
      check("R6 sole increment", rsp_old, DW'(4 + k));
    end
    clear_reqs();
    @(negedge clk);
    summary();
  end
endmodule